// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Half-Bit Stop Support

This block turns a parallel character into an asynchronous serial frame on a single line. It runs from a clock at sixteen times the bit rate, so every serial bit occupies sixteen clock cycles. A character is written into a one-entry holding register. When the sequencer is idle, or as soon as the frame in progress ends, the character moves into a shift register and a new frame begins without further action from the host.

A frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then the stop interval. The stop interval is one, one and a half, or two bit times. The host sees three status outputs: holding-register-empty, an active-low ready flag that mirrors it, and a transmitter-empty flag. A break input pulls the line low while the sequencer keeps counting through its frame underneath.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset the line is high, `hold_empty_o` and `tx_empty_o` are 1, and `ready_n_o` is 0.
- R2: A frame is a start bit of 0, then the data bits LSB first, with each bit held for 16 clock cycles. `word_len_i` selects the count: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The line drops to the start bit in the cycle after the clock edge at which the sequencer sees a full holding register.
- R3: When `par_en_i` is 1, one parity bit follows the data. If `par_stick_i` is 0, the parity bit makes the count of ones even when `par_even_i` is 1, and odd when `par_even_i` is 0. If `par_stick_i` is 1, the parity bit is the inverse of `par_even_i`. When `par_en_i` is 0, no parity bit is sent.
- R4: With `two_stop_i` at 0 the stop interval is high for 16 cycles. With `two_stop_i` at 1 it is 24 cycles for 5-bit words and 32 cycles for any other word length.
- R5: If the holding register is full when the last stop cycle ends, the next start bit begins on the very next cycle, with no idle gap.
- R6: A write clears `hold_empty_o` at the next edge. The transfer into the shift register sets it again. `ready_n_o` is always its inverse.
- R7: `tx_empty_o` is 1 only when the holding register is empty and no frame is in progress, including its final stop cycle.
- R8: While `break_i` is 1 the line output is 0. Frame timing and status flags continue exactly as if there were no break.
- R9: A write while the holding register is already full replaces the waiting character. Only the newest one is sent.
- R10: With nothing to send and no break, the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversample clock, 16x the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Character to send |
| word_len_i | input | 2 | Data bit count select (00=5 .. 11=8) |
| two_stop_i | input | 1 | Long stop interval select |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | Even parity select, or stick value select |
| par_stick_i | input | 1 | Fixed-value parity select |
| break_i | input | 1 | Force the line low |
| txd_o | output | 1 | Serial line output |
| hold_empty_o | output | 1 | Holding register empty |
| ready_n_o | output | 1 | Active-low ready, inverse of hold_empty_o |
| tx_empty_o | output | 1 | Holding register and shifter both idle |

## Verification
The bench uses the default parameters, DATA_W of 8 and OVERSAMPLE of 16. With these, all four word-length codes are reachable and the half-bit stop lasts exactly eight cycles. The behavioural model is a per-cycle queue of expected line levels built whenever a character is loaded. Because of this, the back-to-back handoff, the replacement of a waiting character, and a break that spans a frame are all compared cycle by cycle against the line and the flags.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_START     = 3'd0,
        TX_DATA      = 3'd1,
        TX_PAR       = 3'd2,
        TX_STOP1     = 3'd3,
        TX_STOP_HALF = 3'd4,
        TX_STOP2     = 3'd5
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } tx_cfg_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_regs_t;

    hold_regs_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d.full = 1'b0;
        end
        // a new write wins over a same-cycle transfer and replaces pending data
        if (wr_i) begin
            hold_d.full = 1'b1;
            hold_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full_o = hold_q.full;
    assign data_o = hold_q.data;

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  tx_cfg_t           cfg_i,
    output logic              par_o
);

    localparam int MIN_W = DATA_W - 3;

    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = (i < MIN_W + int'(cfg_i.wlen)) ? data_i[i] : 1'b0;
        end
        ones_odd = ^masked;
        if (cfg_i.par_stick) begin
            par_o = ~cfg_i.par_even;
        end else if (cfg_i.par_even) begin
            par_o = ones_odd;
        end else begin
            par_o = ~ones_odd;
        end
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  tx_cfg_t                       cfg_i,
    input  logic                          hold_full_i,
    input  logic [DATA_W-1:0]             hold_data_i,
    input  logic                          par_bit_i,
    output logic                          load_o,
    output logic                          line_o,
    output logic                          idle_o,
    output tx_state_e                     state_o,
    output logic [$clog2(OVERSAMPLE)-1:0] cnt_o
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MIN_W = DATA_W - 3;
    localparam int HALF  = OVERSAMPLE / 2;

    typedef struct packed {
        tx_state_e         state;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shift;
        logic              par;
        logic              line;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;
    logic      slot_end;
    logic      half_end;
    logic      last_bit;
    logic      frame_end;

    always_comb begin
        fsm_d     = fsm_q;
        load_o    = 1'b0;
        frame_end = 1'b0;
        slot_end  = (fsm_q.cnt == CNT_W'(OVERSAMPLE - 1));
        half_end  = (fsm_q.cnt == CNT_W'(HALF - 1));
        last_bit  = (int'(fsm_q.idx) == MIN_W - 1 + int'(cfg_i.wlen));
        fsm_d.cnt = fsm_q.cnt + 1'b1;

        unique case (fsm_q.state)
            TX_START: begin
                if (fsm_q.busy) begin
                    if (slot_end) begin
                        fsm_d.state = TX_DATA;
                        fsm_d.cnt   = '0;
                        fsm_d.idx   = '0;
                        fsm_d.line  = fsm_q.shift[0];
                    end
                end else begin
                    fsm_d.cnt = '0;
                    frame_end = 1'b1;
                end
            end
            TX_DATA: begin
                if (slot_end) begin
                    fsm_d.cnt = '0;
                    if (last_bit) begin
                        fsm_d.state = cfg_i.par_en ? TX_PAR : TX_STOP1;
                        fsm_d.line  = cfg_i.par_en ? fsm_q.par : 1'b1;
                    end else begin
                        fsm_d.idx   = fsm_q.idx + 1'b1;
                        fsm_d.shift = fsm_q.shift >> 1;
                        fsm_d.line  = fsm_q.shift[1];
                    end
                end
            end
            TX_PAR: begin
                if (slot_end) begin
                    fsm_d.state = TX_STOP1;
                    fsm_d.cnt   = '0;
                    fsm_d.line  = 1'b1;
                end
            end
            TX_STOP1: begin
                if (slot_end) begin
                    fsm_d.cnt = '0;
                    if (!cfg_i.two_stop) begin
                        frame_end = 1'b1;
                    end else if (cfg_i.wlen == 2'b00) begin
                        fsm_d.state = TX_STOP_HALF;
                    end else begin
                        fsm_d.state = TX_STOP2;
                    end
                end
            end
            TX_STOP_HALF: begin
                if (half_end) begin
                    frame_end = 1'b1;
                end
            end
            TX_STOP2: begin
                if (slot_end) begin
                    frame_end = 1'b1;
                end
            end
            default: begin
                fsm_d.state = TX_START;
                fsm_d.busy  = 1'b0;
            end
        endcase

        // end of frame or idle: start the next character at once if one waits
        if (frame_end) begin
            fsm_d.state = TX_START;
            fsm_d.cnt   = '0;
            if (hold_full_i) begin
                load_o      = 1'b1;
                fsm_d.busy  = 1'b1;
                fsm_d.shift = hold_data_i;
                fsm_d.par   = par_bit_i;
                fsm_d.line  = 1'b0;
            end else begin
                fsm_d.busy = 1'b0;
                fsm_d.line = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fsm_q       <= '0;
            fsm_q.state <= TX_START;
            fsm_q.line  <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign line_o  = fsm_q.line;
    assign idle_o  = (fsm_q.state == TX_START) && !fsm_q.busy;
    assign state_o = fsm_q.state;
    assign cnt_o   = fsm_q.cnt;

endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        word_len_i,
    input  logic              two_stop_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_stick_i,
    input  logic              break_i,
    output logic              txd_o,
    output logic              hold_empty_o,
    output logic              ready_n_o,
    output logic              tx_empty_o
);

    localparam int CNT_W = $clog2(OVERSAMPLE);

    tx_cfg_t           cfg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              par_bit;
    logic              line;
    logic              idle;
    tx_state_e         fsm_state;
    logic [CNT_W-1:0]  fsm_cnt;

    assign cfg.wlen      = word_len_i;
    assign cfg.two_stop  = two_stop_i;
    assign cfg.par_en    = par_en_i;
    assign cfg.par_even  = par_even_i;
    assign cfg.par_stick = par_stick_i;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (wr_i),
        .wdata_i (wr_data_i),
        .load_i  (load),
        .full_o  (hold_full),
        .data_o  (hold_data)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_par (
        .data_i (hold_data),
        .cfg_i  (cfg),
        .par_o  (par_bit)
    );

    uart_tx_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_i       (cfg),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .par_bit_i   (par_bit),
        .load_o      (load),
        .line_o      (line),
        .idle_o      (idle),
        .state_o     (fsm_state),
        .cnt_o       (fsm_cnt)
    );

    assign txd_o        = break_i ? 1'b0 : line;
    assign hold_empty_o = !hold_full;
    assign ready_n_o    = hold_full;
    assign tx_empty_o   = !hold_full && idle;

endmodule

// File: rtl/uart_tx_frac_chk.sv
module uart_tx_frac_chk
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          wr_i,
    input logic                          break_i,
    input logic [1:0]                    word_len_i,
    input logic                          two_stop_i,
    input logic                          txd_o,
    input logic                          hold_empty_o,
    input logic                          tx_empty_o,
    input tx_state_e                     state_i,
    input logic [$clog2(OVERSAMPLE)-1:0] cnt_i
);

    localparam int HALF = OVERSAMPLE / 2;

    p_write_fills_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> !hold_empty_o);

    p_temt_needs_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_empty_o |-> hold_empty_o);

    p_break_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        break_i |-> !txd_o);

    p_idle_high_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_empty_o && !break_i) |-> txd_o);

    p_half_short_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == TX_STOP_HALF) |-> (int'(cnt_i) < HALF));

    p_half_only_5bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == TX_STOP_HALF) |-> (two_stop_i && word_len_i == 2'b00));

    p_temt_rises_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tx_empty_o) |-> (state_i == TX_START));

endmodule

bind uart_tx_frac uart_tx_frac_chk #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_i         (wr_i),
    .break_i      (break_i),
    .word_len_i   (word_len_i),
    .two_stop_i   (two_stop_i),
    .txd_o        (txd_o),
    .hold_empty_o (hold_empty_o),
    .tx_empty_o   (tx_empty_o),
    .state_i      (fsm_state),
    .cnt_i        (fsm_cnt)
);

// File: tb/uart_tx_frac_tb.sv
module uart_tx_frac_tb;

    localparam int DATA_W = 8;
    localparam int OS     = 16;

    logic              clk = 1'b0;
    logic              rst_i = 1'b1;
    logic              wr_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [1:0]        word_len_i = 2'b11;
    logic              two_stop_i = 1'b0;
    logic              par_en_i = 1'b0;
    logic              par_even_i = 1'b0;
    logic              par_stick_i = 1'b0;
    logic              break_i = 1'b0;
    logic              txd_o, hold_empty_o, ready_n_o, tx_empty_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    uart_tx_frac #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE_PARAM())) u_dut (
        .clk_i (clk), .rst_i (rst_i), .wr_i (wr_i), .wr_data_i (wr_data_i),
        .word_len_i (word_len_i), .two_stop_i (two_stop_i), .par_en_i (par_en_i),
        .par_even_i (par_even_i), .par_stick_i (par_stick_i), .break_i (break_i),
        .txd_o (txd_o), .hold_empty_o (hold_empty_o), .ready_n_o (ready_n_o),
        .tx_empty_o (tx_empty_o)
    );

    function automatic int OVERSAMPLE_PARAM();
        return OS;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          m_q[$];
    bit          m_full = 1'b0;
    bit [7:0]    m_data = '0;
    bit          m_inframe = 1'b0;
    bit          m_cur = 1'b1;

    task automatic push_bits(input bit v, input int n);
        for (int k = 0; k < n; k++) m_q.push_back(v);
    endtask

    task automatic build_frame(input bit [7:0] d);
        int nb;
        int ones;
        bit p;
        nb = 5 + int'(word_len_i);
        ones = 0;
        push_bits(1'b0, OS);
        for (int b = 0; b < nb; b++) begin
            push_bits(d[b], OS);
            ones += int'(d[b]);
        end
        if (par_en_i) begin
            if (par_stick_i) p = !par_even_i;
            else if (par_even_i) p = (ones % 2) == 1;
            else p = (ones % 2) == 0;
            push_bits(p, OS);
        end
        push_bits(1'b1, OS);
        if (two_stop_i) push_bits(1'b1, (nb == 5) ? OS / 2 : OS);
    endtask

    always @(posedge clk) begin
        if (rst_i) begin
            m_q.delete();
            m_full = 1'b0;
            m_inframe = 1'b0;
            m_cur = 1'b1;
        end else begin
            if (m_q.size() == 0 && m_full) begin
                build_frame(m_data);
                m_full = 1'b0;
            end
            if (m_q.size() > 0) begin
                m_cur = m_q.pop_front();
                m_inframe = 1'b1;
            end else begin
                m_cur = 1'b1;
                m_inframe = 1'b0;
            end
            if (wr_i) begin
                m_full = 1'b1;
                m_data = wr_data_i;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst_i && !finished) begin
            check(tag, "txd_o", int'(txd_o), int'(break_i ? 1'b0 : m_cur));
            check("R6", "hold_empty_o", int'(hold_empty_o), int'(!m_full));
            check("R6", "ready_n_o", int'(ready_n_o), int'(m_full));
            check("R7", "tx_empty_o", int'(tx_empty_o), int'(!m_full && !m_inframe));
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_cfg(input bit [1:0] wl, input bit ts, input bit pe, input bit pev, input bit pst);
        @(negedge clk);
        word_len_i = wl; two_stop_i = ts; par_en_i = pe; par_even_i = pev; par_stick_i = pst;
    endtask

    task automatic send(input bit [7:0] d);
        @(negedge clk);
        wr_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!tx_empty_o);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_hold_empty();
        do @(negedge clk); while (!hold_empty_o);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset txd_o", int'(txd_o), 1);
        check("R1", "reset hold_empty_o", int'(hold_empty_o), 1);
        check("R1", "reset tx_empty_o", int'(tx_empty_o), 1);
        check("R1", "reset ready_n_o", int'(ready_n_o), 0);

        // R10: idle line stays high with no write
        tag = "R10";
        repeat (20) @(negedge clk);

        // R2: plain frames, all word lengths, no parity, one stop
        tag = "R2";
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0); send(8'h55); wait_idle();
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0); send(8'hA3); wait_idle();
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b0); send(8'hFF); wait_idle();
        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, 1'b0); send(8'h2D); wait_idle();
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0); send(8'h13); wait_idle();

        // R3: parity modes
        tag = "R3";
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0); send(8'h07); wait_idle();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0); send(8'h0F); wait_idle();
        set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b0); send(8'h81); wait_idle();
        set_cfg(2'b01, 1'b0, 1'b1, 1'b0, 1'b0); send(8'h00); wait_idle();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b1); send(8'h5A); wait_idle();
        set_cfg(2'b00, 1'b0, 1'b1, 1'b1, 1'b1); send(8'h1F); wait_idle();

        // R4: long stop intervals
        tag = "R4";
        set_cfg(2'b11, 1'b1, 1'b0, 1'b0, 1'b0); send(8'hC6); wait_idle();
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h0A); wait_idle();
        set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 1'b0); send(8'h15); wait_idle();
        set_cfg(2'b01, 1'b1, 1'b1, 1'b0, 1'b0); send(8'h3C); wait_idle();

        // R5: back-to-back frames, including after a half-bit stop
        tag = "R5";
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h91); wait_hold_empty(); send(8'h6E); wait_hold_empty(); send(8'h42); wait_idle();
        set_cfg(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h0B); wait_hold_empty(); send(8'h14); wait_idle();

        // R9: a second write while full replaces the waiting character
        tag = "R9";
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hE1); wait_hold_empty(); send(8'h22); repeat (5) @(negedge clk); send(8'h7C);
        wait_idle();

        // R8: break in the middle of a frame
        tag = "R8";
        set_cfg(2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
        send(8'hB4); repeat (40) @(negedge clk);
        break_i = 1'b1; repeat (70) @(negedge clk);
        break_i = 1'b0; wait_idle();
        break_i = 1'b1; repeat (10) @(negedge clk);
        break_i = 1'b0; repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=not finished expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule